// File: doc/BRIEF.md
# Hash Message Word Buffer

This block is a small word-wide queue between a memory-mapped write window and the input of a hash engine. Any bus write whose byte address lands inside a fixed window pushes one 32-bit message word. The hash engine drains the queue through a valid/ready stream, on a schedule the block sets itself. A word can only be taken in a cycle after the one in which it was written. When keyed (HMAC) mode is chosen at the start of a hash, draining holds off for a fixed number of cycles while the key padding is processed.

Occupancy is kept as the difference of a write counter and a read counter. Each counter is one bit wider than the slot index. Full, empty and a depth value come from that difference and are meant for a status register. A push that arrives while the queue is full is discarded. It sets a sticky overflow flag and never stalls the bus.

Top module: `msg_word_fifo`

## Requirements
- R1: Once the synchronous active-low reset has been applied, fifoEmpty is 1, fifoFull is 0, fifoDepth is 0, outValid is 0 and overflowFlag is 0.
- R2: A write is accepted only when busWrValid is high and busWrAddr lies from 0x800 up to and including 0xFFF. An accepted write raises fifoDepth by one at the next edge. A write to any address below 0x800 leaves fifoDepth and the stream unchanged.
- R3: fifoFull is 1 exactly when 16 words are held. A write accepted by address while the queue is full is dropped: depth stays 16 and the stored words are not altered. The drop sets overflowFlag, which stays 1 until reset. A start pulse does not clear it.
- R4: Words leave on outData in the order in which they were written, with their exact 32-bit values.
- R5: A word written into an empty queue is not offered in the cycle of its write. Where no padding wait is running, outValid is 1 in the following cycle.
- R6: A start pulse with keyedMode at 1 keeps outValid at 0 for 79 cycles after the start edge. Stored words are offered from the 80th cycle on. Writes during that wait are still accepted.
- R7: A start pulse with keyedMode at 0 adds no wait. A word written in the cycle after the start is offered one cycle later.
- R8: A start pulse empties the queue at its edge. A write in the same cycle as the start is discarded and does not count as an overflow.
- R9: A word is removed only in a cycle where outValid and outReady are both 1. With outReady at 0, outData and fifoDepth hold.
- R10: fifoDepth always equals accepted writes minus removals since the last reset or start. It ranges from 0 to 16. fifoEmpty is 1 exactly when fifoDepth is 0, and outValid is never 1 while empty.
- R11: Reset issued in the middle of a padding wait, with overflow set, clears the counters, the wait timer and overflowFlag. The next written word is offered one cycle after its write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| startPulse | input | 1 | One-cycle start of a new hash; clears the queue and arms the wait |
| keyedMode | input | 1 | Sampled with startPulse; 1 selects the key padding wait |
| busWrValid | input | 1 | Bus write strobe |
| busWrAddr | input | 12 | Bus write byte address |
| busWrData | input | 32 | Bus write data |
| outValid | output | 1 | A message word is offered to the hash engine |
| outData | output | 32 | Offered message word |
| outReady | input | 1 | Hash engine takes the offered word |
| fifoFull | output | 1 | 16 words held |
| fifoEmpty | output | 1 | No word held |
| fifoDepth | output | 5 | Number of words held, 0 to 16 |
| overflowFlag | output | 1 | Sticky: a write was dropped while full |

## Verification
A counter that slips shows up at once on fifoDepth and on the full and empty flags, one edge after the push or pop that caused it. A ring pointer that drifts away from the counters shows up as a wrong or repeated word on outData at the next removal. An error in the padding timer moves the first rise of outValid after a keyed start off cycle 80, and the bench measures that rise to the exact cycle. The long mixed push and pop sweep compares depth, flags and the head word against an arithmetic model in every cycle, so a fault is reported in the cycle it appears.

// File: rtl/msgq_pkg.sv
package msgq_pkg;

  // strobes from the control to the datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } msgq_strobe_t;

  function automatic logic addrInWindow(input logic [31:0] addr,
                                        input logic [31:0] lo,
                                        input logic [31:0] hi);
    return (addr >= lo) && (addr <= hi);
  endfunction

endpackage

// File: rtl/msgq_datapath.sv
module msgq_datapath
  import msgq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  msgq_strobe_t      strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic [IDX_W-1:0]  wrPtr, rdPtr;
  logic [DATA_W-1:0] slots [DEPTH];
  logic [DEPTH-1:0]  slotWe;

  // one write enable per slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_slotWe
    assign slotWe[i] = strb.push && (wrPtr == IDX_W'(i));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (slotWe[i]) slots[i] <= wrData;
    end
  end

  // ring pointers wrap naturally with power-of-two depth
  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= wrPtr + 1'b1;
      if (strb.pop)  rdPtr <= rdPtr + 1'b1;
    end
  end

  assign rdData = slots[rdPtr];

endmodule

// File: rtl/msgq_ctrl.sv
module msgq_ctrl
  import msgq_pkg::*;
#(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned WIN_LO     = 32'h800,
  parameter int unsigned WIN_HI     = 32'hFFF,
  parameter int unsigned PAD_CYCLES = 80,
  localparam int unsigned DEPTH_W   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic               keyedMode,
  input  logic               busWrValid,
  input  logic [ADDR_W-1:0]  busWrAddr,
  input  logic               outReady,
  output msgq_strobe_t       strb,
  output logic               outValid,
  output logic               fifoFull,
  output logic               fifoEmpty,
  output logic [DEPTH_W-1:0] fifoDepth,
  output logic               overflowFlag
);

  localparam int unsigned CNT_W = $clog2(DEPTH) + 1;
  localparam int unsigned TMR_W = (PAD_CYCLES < 1) ? 1 : $clog2(PAD_CYCLES + 1);
  localparam logic [TMR_W-1:0] PAD_LOAD = TMR_W'(PAD_CYCLES);

  logic [CNT_W-1:0] wrCnt, rdCnt, occ;
  logic [TMR_W-1:0] padTimer;
  logic             padDone, addrHit, pushOk, pushDrop, popOk;

  assign occ       = wrCnt - rdCnt;
  assign fifoFull  = (occ == CNT_W'(DEPTH));
  assign fifoEmpty = (wrCnt == rdCnt);
  assign fifoDepth = DEPTH_W'(occ);
  assign padDone   = (padTimer == '0);

  assign addrHit  = busWrValid && addrInWindow(32'(busWrAddr), WIN_LO, WIN_HI);
  assign pushOk   = addrHit && !fifoFull && !startPulse;
  assign pushDrop = addrHit &&  fifoFull && !startPulse;

  assign outValid = !fifoEmpty && padDone;
  assign popOk    = outValid && outReady && !startPulse;

  assign strb.push  = pushOk;
  assign strb.pop   = popOk;
  assign strb.clear = startPulse;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrCnt    <= '0;
      rdCnt    <= '0;
      padTimer <= '0;
    end else if (startPulse) begin
      wrCnt    <= '0;
      rdCnt    <= '0;
      padTimer <= keyedMode ? PAD_LOAD : '0;
    end else begin
      if (pushOk)   wrCnt    <= wrCnt + 1'b1;
      if (popOk)    rdCnt    <= rdCnt + 1'b1;
      if (!padDone) padTimer <= padTimer - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         overflowFlag <= 1'b0;
    else if (pushDrop) overflowFlag <= 1'b1;
  end

  // R8: start empties the queue at its edge
  p_start_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (fifoEmpty && !outValid));

  // R3: with no removal, a full queue stays full
  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && !popOk && !startPulse) |=> fifoFull);

  // R3: overflow is sticky until reset
  p_no_overflow_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |=> overflowFlag);

  // R10: depth stays within its range
  p_depth_range_r10: assert property (@(posedge clk) disable iff (!rstN)
    fifoDepth <= DEPTH_W'(DEPTH));

  if (PAD_CYCLES > 0) begin : g_padChk
    // R6: a keyed start offers nothing in the next cycle
    p_keyed_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
      (startPulse && keyedMode) |=> !outValid);
  end

endmodule

// File: rtl/msg_word_fifo.sv
module msg_word_fifo
  import msgq_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned WIN_LO     = 32'h800,
  parameter int unsigned WIN_HI     = 32'hFFF,
  parameter int unsigned PAD_CYCLES = 80
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         startPulse,
  input  logic                         keyedMode,
  input  logic                         busWrValid,
  input  logic [ADDR_W-1:0]            busWrAddr,
  input  logic [DATA_W-1:0]            busWrData,
  output logic                         outValid,
  output logic [DATA_W-1:0]            outData,
  input  logic                         outReady,
  output logic                         fifoFull,
  output logic                         fifoEmpty,
  output logic [$clog2(DEPTH+1)-1:0]   fifoDepth,
  output logic                         overflowFlag
);

  msgq_strobe_t strb;

  msgq_ctrl #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI),
    .PAD_CYCLES(PAD_CYCLES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .keyedMode(keyedMode),
    .busWrValid(busWrValid), .busWrAddr(busWrAddr), .outReady(outReady),
    .strb(strb), .outValid(outValid), .fifoFull(fifoFull),
    .fifoEmpty(fifoEmpty), .fifoDepth(fifoDepth), .overflowFlag(overflowFlag)
  );

  msgq_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(busWrData), .rdData(outData)
  );

  // R9: a stalled offer keeps its word
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !startPulse) |=> (outValid && $stable(outData)));

  // R5: nothing is offered while empty
  p_empty_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    fifoEmpty |-> !outValid);

endmodule

// File: tb/tb_msg_word_fifo.sv
`timescale 1ns/1ps
module tb_msg_word_fifo;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0, keyedMode = 1'b0;
  logic        busWrValid = 1'b0;
  logic [11:0] busWrAddr = '0;
  logic [31:0] busWrData = '0;
  logic        outValid, outReady = 1'b0;
  logic [31:0] outData;
  logic        fifoFull, fifoEmpty, overflowFlag;
  logic [4:0]  fifoDepth;

  int nChecks = 0;
  int nFail   = 0;

  always #5 clk = ~clk;

  msg_word_fifo dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .keyedMode(keyedMode),
    .busWrValid(busWrValid), .busWrAddr(busWrAddr), .busWrData(busWrData),
    .outValid(outValid), .outData(outData), .outReady(outReady),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .fifoDepth(fifoDepth),
    .overflowFlag(overflowFlag)
  );

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  function automatic logic [31:0] pat(input int i);
    return 32'h1000_0000 ^ (32'(i) * 32'h0009_E37B);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] mq [16];
    int mHead, mCnt, firstK;
    logic mOvf;
    logic [15:0] lfsr;

    // reset
    repeat (3) step();
    rstN = 1'b1;
    step();
    chk(fifoEmpty == 1 && fifoFull == 0, "R1 flags", {fifoEmpty, fifoFull}, 2'b10);
    chk(fifoDepth == 0, "R1 depth", fifoDepth, 0);
    chk(outValid == 0 && overflowFlag == 0, "R1 valid/ovf", {outValid, overflowFlag}, 0);

    // R2: writes below the window are ignored
    for (int a = 0; a < 16; a++) begin
      busWrValid = 1; busWrAddr = 12'(a * 128 + (a == 15 ? 127 : 0)); busWrData = 32'hBAD0 + 32'(a);
      step();
      chk(fifoDepth == 0 && outValid == 0, "R2 outside window", fifoDepth, 0);
    end

    // R2/R3/R10: fill through the whole window
    for (int i = 0; i < 16; i++) begin
      busWrValid = 1; busWrAddr = (i == 15) ? 12'hFFF : 12'(12'h800 + i * 128); busWrData = pat(i);
      step();
      chk(fifoDepth == 5'(i + 1), "R2 depth step", fifoDepth, i + 1);
      chk(fifoFull == (i == 15) && fifoEmpty == 0, "R3 full flag", fifoFull, (i == 15));
    end
    // R3: push while full is dropped
    busWrAddr = 12'h800; busWrData = 32'hDEAD_BEEF;
    step();
    busWrValid = 0;
    chk(fifoDepth == 16 && fifoFull, "R3 drop depth", fifoDepth, 16);
    chk(overflowFlag == 1, "R3 overflow set", overflowFlag, 1);

    // R9: stall holds data and depth
    for (int s = 0; s < 3; s++) begin
      step();
      chk(outValid && outData == pat(0), "R9 stall data", outData, pat(0));
      chk(fifoDepth == 16, "R9 stall depth", fifoDepth, 16);
    end

    // R4: drain in order
    outReady = 1;
    for (int i = 0; i < 16; i++) begin
      chk(outValid && outData == pat(i), "R4 order", outData, pat(i));
      step();
    end
    outReady = 0;
    chk(fifoEmpty && !outValid && fifoDepth == 0, "R10 empty after drain", fifoDepth, 0);
    chk(overflowFlag == 1, "R3 overflow sticky", overflowFlag, 1);

    // R5: no same-cycle consumption
    outReady = 1; busWrValid = 1; busWrAddr = 12'h900; busWrData = 32'h5555_AAAA;
    step();
    busWrValid = 0;
    chk(fifoDepth == 1 && outValid && outData == 32'h5555_AAAA, "R5 lag", fifoDepth, 1);
    step();
    outReady = 0;
    chk(fifoDepth == 0 && fifoEmpty, "R5 popped next", fifoDepth, 0);

    // R8: start clears and discards a same-cycle write
    for (int i = 0; i < 3; i++) begin
      busWrValid = 1; busWrAddr = 12'hA00; busWrData = pat(40 + i);
      step();
    end
    startPulse = 1; keyedMode = 0; busWrData = 32'h0BAD_0BAD;
    step();
    startPulse = 0; busWrValid = 0;
    chk(fifoDepth == 0 && fifoEmpty && !outValid, "R8 start clear", fifoDepth, 0);
    chk(overflowFlag == 1, "R3 start keeps overflow", overflowFlag, 1);

    // R7: plain start has no wait
    busWrValid = 1; busWrAddr = 12'hC00; busWrData = 32'h7777_0001;
    step();
    busWrValid = 0;
    chk(outValid && outData == 32'h7777_0001, "R7 no wait", outValid, 1);

    // R6: keyed wait of 80 cycles
    startPulse = 1; keyedMode = 1;
    step();
    startPulse = 0; keyedMode = 0;
    busWrValid = 1; busWrAddr = 12'hD00; busWrData = 32'h4242_4242;
    firstK = -1;
    for (int k = 1; k <= 120; k++) begin
      step();
      busWrValid = 0;
      if (k == 40) chk(fifoDepth == 1 && !outValid, "R6 write during wait", fifoDepth, 1);
      if (outValid && firstK < 0) firstK = k;
    end
    chk(firstK == 80, "R6 first offer cycle", firstK, 80);
    chk(outData == 32'h4242_4242, "R6 data", outData, 32'h4242_4242);

    // R11: reset during wait
    startPulse = 1; keyedMode = 1;
    step();
    startPulse = 0; keyedMode = 0;
    busWrValid = 1; busWrAddr = 12'hE00; busWrData = 32'h1;
    step(); step();
    busWrValid = 0;
    rstN = 0;
    step();
    rstN = 1;
    step();
    chk(fifoDepth == 0 && fifoEmpty && overflowFlag == 0, "R11 reset clear", {fifoDepth, overflowFlag}, 0);
    busWrValid = 1; busWrData = 32'h0000_0A11;
    step();
    busWrValid = 0;
    chk(outValid && outData == 32'h0000_0A11, "R11 timer cleared", outValid, 1);
    startPulse = 1;
    step();
    startPulse = 0;

    // R4/R10: mixed push/pop sweep against a model
    mHead = 0; mCnt = 0; mOvf = 0; lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      logic bias, wv, rd, inWin, popNow;
      logic [11:0] addr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      bias = ((n / 500) % 2) == 0;
      wv   = bias ? (lfsr[0] | lfsr[5]) : (lfsr[0] & lfsr[5]);
      rd   = bias ? (lfsr[3] & lfsr[7]) : (lfsr[3] | lfsr[7]);
      inWin = (lfsr[9:8] != 2'b00);
      addr = inWin ? (12'h800 | {1'b0, lfsr[10:0]}) : {1'b0, lfsr[10:0]};
      chk(fifoDepth == 5'(mCnt), "R10 sweep depth", fifoDepth, mCnt);
      chk(fifoEmpty == (mCnt == 0) && fifoFull == (mCnt == 16), "R10 sweep flags",
          {fifoEmpty, fifoFull}, {(mCnt == 0), (mCnt == 16)});
      chk(outValid == (mCnt > 0), "R10 sweep valid", outValid, (mCnt > 0));
      if (mCnt > 0) chk(outData == mq[mHead], "R4 sweep data", outData, mq[mHead]);
      chk(overflowFlag == mOvf, "R3 sweep overflow", overflowFlag, mOvf);
      busWrValid = wv; busWrAddr = addr; busWrData = pat(1000 + n); outReady = rd;
      popNow = (mCnt > 0) && rd;
      if (wv && inWin) begin
        if (mCnt == 16) mOvf = 1;
        else mq[(mHead + mCnt) % 16] = pat(1000 + n);
      end
      if (wv && inWin && mCnt < 16) mCnt++;
      if (popNow) begin
        mHead = (mHead + 1) % 16;
        mCnt--;
      end
      step();
    end
    busWrValid = 0; outReady = 0;

    summary();
    $finish;
  end

endmodule